// File: doc/BRIEF.md
# Carryless 128-bit CRC fold stage

This block keeps a 128-bit running value of a message and pushes it forward by one fixed stride each time a new 16-byte block arrives. The running value is cut into an upper and a lower 64-bit half. Each half is multiplied in GF(2) by a constant congruent to a power of x modulo the CRC polynomial. The two products and the incoming block are XORed together. The result stays congruent, modulo the polynomial, to the whole message seen so far. A final reduction stage outside this block can then turn 128 bits into a CRC, whatever the message length.

The block computes no remainder. It only shortens the message while keeping the remainder unchanged. Both fold constants are parameters. The defaults suit a 32-bit CRC with generator x^32 + 0xAF, processed most significant bit first, with a stride of 128 bits. For this 32-bit CRC on a 64-bit datapath, each constant is the 32-bit residue of a power of x placed in the upper 32 bits of the 64-bit constant.

Blocks arrive in memory order, with the first message byte in the lowest byte lane. The block swaps the byte order so that the first byte becomes the most significant byte. A CRC with a non-zero initial value is supported by XORing that value into the first four message bytes before they are fed in.

Top module: `crc_fold128`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it rises, `acc_o` is all zeros.
- R2: A clock edge with `in_valid` and `in_first` both high loads the byte-reversed block: `in_data[8k+7:8k]` appears at `acc_o[127-8k -: 8]` for k = 0..15.
- R3: A clock edge with `in_valid` high and `in_first` low sets `acc_o` to clmul(`acc_o[63:0]`, K_LO) XOR clmul(`acc_o[127:64]`, K_HI) XOR the byte-reversed block. Here clmul is the 128-bit carryless product, in which each product bit is the XOR of the partial ANDs.
- R4: When `in_valid` is low, `acc_o` keeps its value and `in_first` has no effect.
- R5: With the default constants, the CRC of the 16 bytes of `acc_o`, taken from bits 127:120 first (generator 0x1_000000AF, MSB first, init 0, no final XOR), equals the CRC of every byte fed in so far.
- R6: A fold with `acc_o` all zeros gives exactly the byte-reversed new block.
- R7: By default, K_LO is (x^96 mod P) << 32 and K_HI is (x^160 mod P) << 32. These are the constants for a 128-bit stride, where the lower half moves forward by the stride D and the upper half by D + 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A data block is present this cycle |
| in_first | input | 1 | The present block starts a new message (load, not fold) |
| in_data | input | 128 | 16 message bytes, first byte in bits 7:0 |
| acc_o | output | 128 | Folded running value, first byte in bits 127:120 |

## Verification
The properties assume that `in_valid`, `in_first` and `in_data` are driven to known values on every sampled edge once reset is released. They also assume that a message always begins with a block marked `in_first`, because a fold only makes sense on top of a loaded value. The stimulus changes inputs only on the falling clock edge. It holds `in_valid` low throughout reset, and it opens every message with a first block before any fold. Idle cycles are placed between blocks with `in_first` toggled, so that the hold property is exercised with a misleading flag.

// File: rtl/crc_fold128.sv
module crc_fold128 #(
  parameter logic [63:0] K_LO = 64'h00295F23_00000000,
  parameter logic [63:0] K_HI = 64'hFAFA5179_00000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic [127:0] in_data,
  output logic [127:0] acc_o
);

  function automatic logic [127:0] clmul64(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p;
    p = '0;
    for (int i = 0; i < 64; i++)
      if (b[i]) p = p ^ ({64'b0, a} << i);
    return p;
  endfunction

  function automatic logic [127:0] bswap(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 16; k++)
      r[127-8*k -: 8] = d[8*k +: 8];
    return r;
  endfunction

  logic [127:0] acc_q, blk, moved;

  assign blk   = bswap(in_data);
  assign moved = clmul64(acc_q[63:0], K_LO) ^ clmul64(acc_q[127:64], K_HI);
  assign acc_o = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (in_valid)
      acc_q <= in_first ? blk : (moved ^ blk);
  end

endmodule

module crc_fold128_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_first,
  input logic [127:0] in_data,
  input logic [127:0] acc_o
);

  function automatic logic [127:0] rev_bytes(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 16; k++)
      r[8*k +: 8] = d[127-8*k -: 8];
    return r;
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> acc_o == '0); // R1

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first) |=> rev_bytes(acc_o) == $past(in_data)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_o)); // R4

  AST_ZERO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && acc_o == '0) |=> rev_bytes(acc_o) == $past(in_data)); // R6

endmodule

bind crc_fold128 crc_fold128_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .in_data(in_data), .acc_o(acc_o)
);

// File: tb/test_crc_fold128.sv
module test_crc_fold128;
  localparam int FOLD_BITS = 128;

  logic clk = 0, rst_n = 0, in_valid = 0, in_first = 0;
  logic [127:0] in_data = '0;
  logic [127:0] acc_o;
  int checks = 0, errors = 0;
  bit done = 0;

  crc_fold128 i_crc_fold128 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_first(in_first), .in_data(in_data), .acc_o(acc_o));

  always #2 clk = ~clk;

  function automatic logic [31:0] xpow(input int n);
    logic [32:0] r;
    r = 33'd1;
    for (int i = 0; i < n; i++) begin
      r = r << 1;
      if (r[32]) r = r ^ 33'h1_000000AF;
    end
    return r[31:0];
  endfunction

  function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p;
    p = '0;
    for (int j = 0; j < 64; j++)
      for (int i = 0; i < 64; i++)
        p[i+j] = p[i+j] ^ (a[i] & b[j]);
    return p;
  endfunction

  function automatic logic [127:0] swap16(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[127-8*k -: 8] = d[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] x;
    x = c ^ {b, 24'h0};
    for (int i = 0; i < 8; i++) x = x[31] ? ((x << 1) ^ 32'h0000_00AF) : (x << 1);
    return x;
  endfunction

  function automatic logic [31:0] crc_acc(input logic [127:0] v);
    logic [31:0] c;
    c = 32'h0;
    for (int k = 0; k < 16; k++) c = crc_step(c, v[127-8*k -: 8]);
    return c;
  endfunction

  logic [63:0] k_lo, k_hi;

  task automatic check128(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic first, input logic [127:0] d);
    @(negedge clk);
    in_valid = 1; in_first = first; in_data = d;
    @(negedge clk);
    in_valid = 0; in_first = 0;
  endtask

  task automatic t_reset;
    check128("R1 during reset", acc_o, '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check128("R1 after reset", acc_o, '0);
  endtask

  task automatic t_load;
    logic [127:0] d = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    push(1, d);
    check128("R2 load byte order", acc_o, 128'h00010203_04050607_08090A0B_0C0D0E0F);
    push(1, 128'h8877_6655_4433_2211_FFEE_DDCC_BBAA_9988);
    check128("R2 reload", acc_o, swap16(128'h8877_6655_4433_2211_FFEE_DDCC_BBAA_9988));
  endtask

  task automatic t_fold;
    logic [127:0] a = 128'h8000_0000_0000_0001_0000_0000_0000_0001;
    logic [127:0] d = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA;
    logic [127:0] e;
    push(1, swap16(a));
    e = ref_mul(a[63:0], k_lo) ^ ref_mul(a[127:64], k_hi) ^ swap16(d);
    push(0, d);
    check128("R3/R7 fold single bits", acc_o, e);
    a = acc_o;
    d = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    e = ref_mul(a[63:0], k_lo) ^ ref_mul(a[127:64], k_hi) ^ swap16(d);
    push(0, d);
    check128("R3/R7 fold dense", acc_o, e);
  endtask

  task automatic t_idle;
    logic [127:0] held = acc_o;
    @(negedge clk); in_valid = 0; in_first = 1; in_data = '1;
    @(negedge clk); in_first = 0; in_data = 128'h5A;
    @(negedge clk);
    check128("R4 idle hold", acc_o, held);
  endtask

  task automatic t_zero;
    logic [127:0] d = 128'hCAFE_F00D_0000_1234_0000_0000_ABCD_0001;
    push(1, '0);
    check128("R2 zero load", acc_o, '0);
    push(0, d);
    check128("R6 zero fold", acc_o, swap16(d));
  endtask

  task automatic t_crc_msg(input int nblk, input int seed);
    logic [7:0] msg [64];
    logic [31:0] c_msg;
    logic [127:0] blk;
    for (int i = 0; i < 64; i++) msg[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
    c_msg = 32'hFFFF_FFFF;
    for (int b = 0; b < nblk; b++) begin
      for (int k = 0; k < 16; k++) begin
        c_msg = crc_step(c_msg, msg[16*b+k]);
        blk[8*k +: 8] = (b == 0 && k < 4) ? (msg[k] ^ 8'hFF) : msg[16*b+k];
      end
      push(b == 0, blk);
      check128("R5 crc preserved", {96'h0, crc_acc(acc_o)}, {96'h0, c_msg});
    end
  endtask

  task automatic t_model;
    logic [31:0] c = 32'hFFFF_FFFF;
    string s = "123456789";
    for (int i = 0; i < 9; i++) c = crc_step(c, s[i]);
    check128("R5 model check value", {96'h0, c}, {96'h0, 32'hA5FD_3138});
    check128("R7 low constant", {64'h0, k_lo}, {64'h0, 64'h00295F23_00000000});
  endtask

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    k_lo = {xpow(FOLD_BITS - 32), 32'h0};
    k_hi = {xpow(FOLD_BITS + 64 - 32), 32'h0};
    t_reset;
    t_model;
    t_load;
    t_fold;
    t_idle;
    t_zero;
    t_crc_msg(2, 1);
    t_crc_msg(4, 7);
    t_idle;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule